// File: doc/BRIEF.md
# Serial Read-Command Parser

This block sits behind a serial byte receiver. It watches the incoming bytes, each marked by a one-cycle valid strobe, and looks for a two-character read request. The first character is the letter `R` and the second is one upper-case hexadecimal digit. When such a pair completes, the block loads a zero-extended memory address and then raises a one-cycle start strobe for the downstream memory-read engine.

A lead byte that is not `R` is dropped, and the parser keeps waiting for a lead. This lets a stream that has lost its framing realign by itself. A second character that is not a hex digit still completes the request. In that case it loads a fixed fallback address and raises an error flag alongside the start strobe. Bytes are consumed only in cycles where the valid strobe is high.

Top module: `rdcmd_parser`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the cycle after it, `addr` is 0 and `start_read` and `cmd_error` are low.
- R2: A first byte other than 0x52 (`R`) is discarded. A hex digit that follows it produces no `start_read` and leaves `addr` unchanged. A later 0x52 begins a normal request.
- R3: A second byte of 0x30..0x39 (`0`..`9`) loads `addr` with 0..9 and reports `cmd_error` low.
- R4: A second byte of 0x41..0x46 (`A`..`F`) loads `addr` with 0xA..0xF and reports `cmd_error` low.
- R5: Any other second byte (lower-case letters, punctuation, 0x52 itself) loads the fallback address 0x00000E and reports `cmd_error` high with the start strobe.
- R6: `addr` bits 23..4 are always zero. The decoded value occupies bits 3..0.
- R7: `addr` changes at the clock edge that accepts the second byte. `start_read` is high for exactly one cycle, beginning one cycle later, and `addr` does not change while it is high.
- R8: `cmd_error` changes only together with `start_read`. It keeps its value through idle cycles and through an unfinished request, until the next request completes.
- R9: A cycle with `rx_valid` low never advances the parser, whatever value is on `rx_byte`.
- R10: After a request completes, the parser waits for a new lead byte. A byte that arrives straight after the digit is treated as a lead, with no gap cycle needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` as a new byte |
| addr | output | 24 | Decoded read address |
| start_read | output | 1 | One-cycle strobe to start a memory read |
| cmd_error | output | 1 | Fallback address was substituted in the last request |

## Verification
The hardest state to reach from the ports is a parser that is half-way through a request while idle cycles carry a lead-like value on the data bus. From outside, such a state looks the same as an idle parser. The stimulus sends a lone `R`, then holds `rx_valid` low for several cycles with 0x52 on `rx_byte`, and then supplies a digit. The digit must finish that same request, and `cmd_error` must keep its earlier error value throughout. Realignment is driven by continuous byte streams in which a digit arrives where a lead is expected, and the strobe count is checked afterwards.

// File: rtl/rdcmd_pkg.sv
package rdcmd_pkg;
   // position of the parser inside a two-byte request
   typedef enum logic {
      POS_LEAD  = 1'b0,
      POS_DIGIT = 1'b1
   } rdcmd_pos_e;

   localparam int NIB_W = 4;
endpackage

// File: rtl/rdcmd_hexdec.sv
module rdcmd_hexdec #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0]          code_i,
   output logic [rdcmd_pkg::NIB_W-1:0] nib_o,
   output logic                       bad_o
);
   localparam logic [BYTE_W-1:0] DIG_LO = BYTE_W'(8'h30);
   localparam logic [BYTE_W-1:0] DIG_HI = BYTE_W'(8'h39);
   localparam logic [BYTE_W-1:0] LET_LO = BYTE_W'(8'h41);
   localparam logic [BYTE_W-1:0] LET_HI = BYTE_W'(8'h46);

   always_comb begin
      nib_o = '0;
      bad_o = 1'b1;
      if (code_i >= DIG_LO && code_i <= DIG_HI) begin
         nib_o = code_i[3:0];
         bad_o = 1'b0;
      end else if (code_i >= LET_LO && code_i <= LET_HI) begin
         nib_o = code_i[3:0] + 4'd9;
         bad_o = 1'b0;
      end
   end
endmodule

// File: rtl/rdcmd_seq.sv
module rdcmd_seq #(
   parameter int                BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] LEAD_CODE = BYTE_W'(8'h52)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] code_i,
   input  logic              valid_i,
   output logic              take_digit_o
);
   import rdcmd_pkg::*;

   rdcmd_pos_e pos_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= POS_LEAD;
      end else if (valid_i) begin
         case (pos_q)
            POS_LEAD:  if (code_i == LEAD_CODE) pos_q <= POS_DIGIT;
            POS_DIGIT: pos_q <= POS_LEAD;
            default:   pos_q <= POS_LEAD;
         endcase
      end
   end

   assign take_digit_o = valid_i && (pos_q == POS_DIGIT);
endmodule

// File: rtl/rdcmd_outreg.sv
module rdcmd_outreg #(
   parameter int                ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] ERR_ADDR = ADDR_W'(4'hE)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        load_i,
   input  logic [rdcmd_pkg::NIB_W-1:0] nib_i,
   input  logic                        bad_i,
   output logic [ADDR_W-1:0]           addr_o,
   output logic                        start_o,
   output logic                        err_o
);
   localparam int PAD_W = ADDR_W - rdcmd_pkg::NIB_W;

   logic [ADDR_W-1:0] load_val;
   logic              fire_q;
   logic              bad_q;

   generate
      if (PAD_W > 0) begin : g_pad
         assign load_val = bad_i ? ERR_ADDR : {{PAD_W{1'b0}}, nib_i};
      end else begin : g_nopad
         assign load_val = bad_i ? ERR_ADDR : nib_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_o  <= '0;
         fire_q  <= 1'b0;
         bad_q   <= 1'b0;
         start_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         fire_q  <= load_i;
         start_o <= fire_q;
         if (load_i) begin
            addr_o <= load_val;
            bad_q  <= bad_i;
         end
         if (fire_q) err_o <= bad_q;
      end
   end
endmodule

// File: rtl/rdcmd_parser.sv
module rdcmd_parser #(
   parameter int                ADDR_W    = 24,
   parameter int                BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] LEAD_CODE = BYTE_W'(8'h52),
   parameter logic [ADDR_W-1:0] ERR_ADDR  = ADDR_W'(4'hE)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_valid,
   output logic [ADDR_W-1:0] addr,
   output logic              start_read,
   output logic              cmd_error
);
   localparam int NIB_W = rdcmd_pkg::NIB_W;

   generate
      if (ADDR_W < NIB_W) begin : g_chk_addr
         $error("rdcmd_parser: ADDR_W must hold one hex digit");
      end
      if (BYTE_W < 7) begin : g_chk_byte
         $error("rdcmd_parser: BYTE_W must hold 7-bit character codes");
      end
      if ((ERR_ADDR >> NIB_W) != 0) begin : g_chk_err
         $error("rdcmd_parser: ERR_ADDR must be a single-digit address");
      end
   endgenerate

   logic             take_digit;
   logic [NIB_W-1:0] nib;
   logic             bad;

   rdcmd_seq #(
      .BYTE_W   (BYTE_W),
      .LEAD_CODE(LEAD_CODE)
   ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .code_i      (rx_byte),
      .valid_i     (rx_valid),
      .take_digit_o(take_digit)
   );

   rdcmd_hexdec #(
      .BYTE_W(BYTE_W)
   ) u_dec (
      .code_i(rx_byte),
      .nib_o (nib),
      .bad_o (bad)
   );

   rdcmd_outreg #(
      .ADDR_W  (ADDR_W),
      .ERR_ADDR(ERR_ADDR)
   ) u_out (
      .clk    (clk),
      .rst    (rst),
      .load_i (take_digit),
      .nib_i  (nib),
      .bad_i  (bad),
      .addr_o (addr),
      .start_o(start_read),
      .err_o  (cmd_error)
   );
endmodule

// File: rtl/rdcmd_parser_chk.sv
module rdcmd_parser_chk #(
   parameter int                ADDR_W   = 24,
   parameter int                BYTE_W   = 8,
   parameter logic [ADDR_W-1:0] ERR_ADDR = ADDR_W'(4'hE)
) (
   input logic              clk,
   input logic              rst,
   input logic [BYTE_W-1:0] rx_byte,
   input logic              rx_valid,
   input logic [ADDR_W-1:0] addr,
   input logic              start_read,
   input logic              cmd_error
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (addr == '0 && !start_read && !cmd_error));

   assert_err_addr_R5: assert property (@(posedge clk) disable iff (rst)
      (start_read && cmd_error) |-> (addr == ERR_ADDR));

   assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (addr >> 4) == '0);

   assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
      start_read |=> !start_read);

   assert_addr_settled_R7: assert property (@(posedge clk) disable iff (rst)
      start_read |-> $stable(addr));

   assert_err_moves_with_start_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(cmd_error) |-> start_read);

   assert_start_needs_byte_R9: assert property (@(posedge clk) disable iff (rst)
      start_read |-> $past(rx_valid, 2));

   logic unused_ok;
   assign unused_ok = ^rx_byte;
endmodule

bind rdcmd_parser rdcmd_parser_chk #(
   .ADDR_W  (ADDR_W),
   .BYTE_W  (BYTE_W),
   .ERR_ADDR(ERR_ADDR)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rx_byte   (rx_byte),
   .rx_valid  (rx_valid),
   .addr      (addr),
   .start_read(start_read),
   .cmd_error (cmd_error)
);

// File: tb/sim_rdcmd_parser.sv
`timescale 1ns/1ps
module sim_rdcmd_parser;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  rx_byte = 8'h00;
   logic        rx_valid = 1'b0;
   logic [23:0] addr;
   logic        start_read;
   logic        cmd_error;

   int checks = 0;
   int errors = 0;
   int starts = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rdcmd_parser u0 (
      .clk       (clk),
      .rst       (rst),
      .rx_byte   (rx_byte),
      .rx_valid  (rx_valid),
      .addr      (addr),
      .start_read(start_read),
      .cmd_error (cmd_error)
   );

   always @(negedge clk) if (!rst && start_read) starts++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // present one byte for one cycle; idle cycles carry 0x52 to test R9
   task automatic send(input logic [7:0] b);
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_byte  = 8'h52;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_cmd(input logic [7:0] dig, input logic [23:0] exp_addr,
                             input logic exp_err, input string tag);
      send(dig);
      chk({tag, " addr loaded"}, {8'h0, addr}, {8'h0, exp_addr});
      chk("R7 start waits one cycle", {31'h0, start_read}, 32'h0);
      @(negedge clk);
      chk("R7 start pulse", {31'h0, start_read}, 32'h1);
      chk({tag, " error flag"}, {31'h0, cmd_error}, {31'h0, exp_err});
      chk("R7 addr held at start", {8'h0, addr}, {8'h0, exp_addr});
      chk("R6 upper bits zero", {8'h0, addr[23:4]}, 32'h0);
      @(negedge clk);
      chk("R7 start single cycle", {31'h0, start_read}, 32'h0);
   endtask

   task automatic run_cmd(input logic [7:0] dig, input logic [23:0] exp_addr,
                          input logic exp_err, input string tag);
      send(8'h52);
      finish_cmd(dig, exp_addr, exp_err, tag);
   endtask

   task automatic t_reset;
      chk("R1 addr", {8'h0, addr}, 32'h0);
      chk("R1 start_read", {31'h0, start_read}, 32'h0);
      chk("R1 cmd_error", {31'h0, cmd_error}, 32'h0);
   endtask

   task automatic t_digits;
      for (int i = 0; i < 10; i++) run_cmd(8'h30 + 8'(i), 24'(i), 1'b0, "R3");
   endtask

   task automatic t_letters;
      for (int i = 0; i < 6; i++) run_cmd(8'h41 + 8'(i), 24'(10 + i), 1'b0, "R4");
   endtask

   task automatic t_bad_digits;
      logic [7:0] bad [6] = '{8'h2F, 8'h3A, 8'h40, 8'h47, 8'h61, 8'h52};
      for (int i = 0; i < 6; i++) run_cmd(bad[i], 24'hE, 1'b1, "R5");
      run_cmd(8'h39, 24'h9, 1'b0, "R3 after error");
   endtask

   task automatic t_bad_lead;
      int base = starts;
      send(8'h58);
      send(8'h35);
      send(8'h72);
      send(8'h36);
      idle(4);
      chk("R2 no start after bad lead", 32'(starts), 32'(base));
      chk("R2 addr untouched", {8'h0, addr}, 32'h9);
      run_cmd(8'h35, 24'h5, 1'b0, "R2 realign");
   endtask

   task automatic t_gaps;
      int base;
      run_cmd(8'h3C, 24'hE, 1'b1, "R5 setup");
      base = starts;
      send(8'h52);
      idle(6);
      chk("R9 no progress while invalid", 32'(starts), 32'(base));
      chk("R8 error held mid-request", {31'h0, cmd_error}, 32'h1);
      chk("R9 addr held while invalid", {8'h0, addr}, 32'hE);
      finish_cmd(8'h37, 24'h7, 1'b0, "R9 digit after gap");
      chk("R8 error cleared by good request", {31'h0, cmd_error}, 32'h0);
   endtask

   task automatic t_err_hold;
      run_cmd(8'h67, 24'hE, 1'b1, "R5 lower-case");
      idle(5);
      chk("R8 error held idle", {31'h0, cmd_error}, 32'h1);
      run_cmd(8'h41, 24'hA, 1'b0, "R8 clear");
   endtask

   task automatic t_back_to_back;
      int base = starts;
      send(8'h52);
      send(8'h33);
      send(8'h34);
      send(8'h52);
      send(8'h32);
      idle(3);
      chk("R10 two requests counted", 32'(starts), 32'(base + 2));
      chk("R10 final addr", {8'h0, addr}, 32'h2);
      chk("R10 final error", {31'h0, cmd_error}, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_digits();
      t_letters();
      t_bad_digits();
      t_bad_lead();
      t_gaps();
      t_err_hold();
      t_back_to_back();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule